// File: doc/BRIEF.md
# Page Write Buffer with Address Pointer

This block sits between a two-wire serial memory protocol engine and a byte-wide nonvolatile array. The protocol engine sends it a small set of pulses. It loads a word address when a write sequence begins and hands over each data byte as it arrives. It asks for a commit when the stop condition ends a write, and it steps the address pointer each time a read byte has been consumed. The block keeps the received bytes in a 16-slot page buffer, and each slot has its own valid flag. While a write sequence runs, the slot cursor moves only through the low four address bits, so bytes sent past the end of the page fold back to the page start. When a slot is written twice, the later byte replaces the earlier one.

On a commit, the block scans the page buffer from slot 0 to slot 15, one slot per clock. For every valid slot it issues one array write to the committed page. The busy flag is high for the whole scan, and the block accepts no command while busy is high. The internal pointer appears on the read-address port. After a commit, the pointer holds the value set by the current-address rule, and that value depends on how many bytes were received. If write protect was high at any point in the sequence, the commit is discarded.

Top module: `page_write_buffer`

## Requirements
- R1: While and just after reset, `rd_addr` is 0, `busy` is low and `mem_we` is low.
- R2: An accepted `load_addr` sets `rd_addr` to `load_value` on the next cycle and discards every byte received earlier.
- R3: Each accepted `wr_byte` stores `wr_data` in the slot given by a 4-bit cursor. The cursor starts at `load_value[3:0]` and increments modulo 16 after each byte. A slot written again keeps the newest byte.
- R4: A commit of at least one byte with write protect never seen raises `busy` on the next cycle for exactly 16 cycles. During that time `mem_we` pulses once for each valid slot, in ascending slot order, at address {page of `load_value`, slot}, and there are no other writes.
- R5: After a commit of 1 to 15 bytes, `rd_addr` = {page, (`load_value[3:0]` + byte count) mod 16}. For example, a single byte at offset 15 leaves the pointer at offset 0.
- R6: After a commit of 16 or more bytes, `rd_addr` equals `load_value`.
- R7: An accepted `rd_adv` increments `rd_addr` by one modulo 2048, so 2047 steps to 0.
- R8: A commit with no bytes received performs no write, leaves `busy` low and leaves `rd_addr` unchanged.
- R9: If `wp` is high in any cycle from the `load_addr` cycle through the commit cycle, the commit writes nothing, leaves `busy` low and leaves `rd_addr` unchanged. The received bytes are dropped, so a later commit without a new load writes nothing.
- R10: While `busy` is high, `load_addr`, `wr_byte`, `commit` and `rd_adv` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_addr | input | 1 | Begin a write sequence at `load_value` |
| load_value | input | 11 | Word address for the sequence |
| wr_byte | input | 1 | One received data byte is present |
| wr_data | input | 8 | Received data byte |
| commit | input | 1 | Stop seen: write the buffered bytes |
| rd_adv | input | 1 | A read byte was consumed; step the pointer |
| wp | input | 1 | Write protect level |
| busy | output | 1 | Array write scan in progress |
| rd_addr | output | 11 | Current address pointer (array read address) |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench sends more than 16 bytes into one page. A design that let the cursor carry into the page bits would write into the next page, and one that kept the first byte would write stale data into the overwritten slots. It checks the pointer after 1, 6, 15, 16 and 20 bytes, and after one byte at offset 15. A design that ignored the byte count or let the sum carry would leave the pointer off the page or at the wrong offset. It also raises write protect for a single cycle in the middle of a transfer, and it fires commands while the scan is running. A design without a sticky protect flag, or one that listened while busy, would write the array or move the pointer.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_SCAN = 1'b1
    } drain_state_e;
endpackage

// File: rtl/pwb_slots.sv
// Page buffer: one data byte and one valid flag per slot.
module pwb_slots #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_slot,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SLOTS = 1 << PAGE_W;

    typedef struct packed {
        logic [SLOTS-1:0]             vld;
        logic [SLOTS-1:0][DATA_W-1:0] dat;
    } slots_t;

    slots_t           s_d, s_q;
    logic [SLOTS-1:0] hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_slot == PAGE_W'(g));
    end

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (clr) begin
                s_d.vld[i] = 1'b0;
            end else if (hit[i]) begin
                s_d.vld[i] = 1'b1;
                s_d.dat[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid = s_q.vld[rd_slot];
    assign rd_data  = s_q.dat[rd_slot];
endmodule

// File: rtl/pwb_drain.sv
// Commit sequencer: scans every slot once and writes the valid ones.
module pwb_drain
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ADDR_W-PAGE_W-1:0] page_in,
    input  logic                     slot_valid,
    input  logic [DATA_W-1:0]        slot_data,
    output logic                     busy,
    output logic [PAGE_W-1:0]        scan_slot,
    output logic                     done,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_waddr,
    output logic [DATA_W-1:0]        mem_wdata
);
    localparam int                ROW_W     = ADDR_W - PAGE_W;
    localparam logic [PAGE_W-1:0] SLOT_LAST = '1;

    typedef struct packed {
        drain_state_e      st;
        logic [PAGE_W-1:0] idx;
        logic [ROW_W-1:0]  page;
    } drain_t;

    drain_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        unique case (d_q.st)
            DR_IDLE: begin
                if (start) begin
                    d_d.st   = DR_SCAN;
                    d_d.idx  = '0;
                    d_d.page = page_in;
                end
            end
            DR_SCAN: begin
                if (d_q.idx == SLOT_LAST) d_d.st  = DR_IDLE;
                else                      d_d.idx = d_q.idx + 1'b1;
            end
            default: d_d.st = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '{st: DR_IDLE, idx: '0, page: '0};
        else        d_q <= d_d;
    end

    assign busy      = (d_q.st == DR_SCAN);
    assign scan_slot = d_q.idx;
    assign done      = busy && (d_q.idx == SLOT_LAST);
    assign mem_we    = busy && slot_valid;
    assign mem_waddr = {d_q.page, d_q.idx};
    assign mem_wdata = slot_data;
endmodule

// File: rtl/pwb_pointer.sv
// Internal address pointer: a load has priority over a step.
module pwb_pointer #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_val,
    input  logic              step_en,
    output logic [ADDR_W-1:0] ptr
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ptr_t;

    ptr_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (set_en)       p_d.ptr = set_val;
        else if (step_en) p_d.ptr = p_q.ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign ptr = p_q.ptr;
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] load_value,
    input  logic              wr_byte,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic              rd_adv,
    input  logic              wp,
    output logic              busy,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int ROW_W = ADDR_W - PAGE_W;
    localparam int CNT_W = PAGE_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [PAGE_W-1:0] cursor;
        logic [CNT_W-1:0]  cnt;
        logic              wp_seen;
    } seq_t;

    seq_t              q_d, q_q;
    logic              ld, wr, cm, wp_now, cm_go, cm_blocked;
    logic              drain_done, slot_valid;
    logic [PAGE_W-1:0] scan_slot;
    logic [DATA_W-1:0] slot_data;
    logic [ADDR_W-1:0] commit_ptr;
    logic [CNT_W-1:0]  held_cnt;

    // Command acceptance: nothing is taken while the scan runs; a load wins.
    assign ld         = load_addr && !busy;
    assign wr         = wr_byte && !busy && !load_addr;
    assign cm         = commit && !busy && !load_addr && !wr_byte;
    assign wp_now     = q_q.wp_seen || wp;
    assign cm_blocked = cm && wp_now;
    assign cm_go      = cm && !wp_now && (q_q.cnt != '0);

    // Pointer after commit: the designated address once the page is full,
    // otherwise the address advanced by the byte count inside the page.
    assign commit_ptr = q_q.cnt[PAGE_W] ? q_q.base
                      : {q_q.base[ADDR_W-1:PAGE_W],
                         PAGE_W'(q_q.base[PAGE_W-1:0] + q_q.cnt[PAGE_W-1:0])};

    always_comb begin
        q_d = q_q;
        if (ld) begin
            q_d.base    = load_value;
            q_d.cursor  = load_value[PAGE_W-1:0];
            q_d.cnt     = '0;
            q_d.wp_seen = wp;
        end else begin
            q_d.wp_seen = wp_now;
            if (wr) begin
                q_d.cursor = q_q.cursor + 1'b1;
                if (!q_q.cnt[PAGE_W]) q_d.cnt = q_q.cnt + 1'b1;
            end
            if (cm) begin
                q_d.cnt     = '0;
                q_d.wp_seen = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign held_cnt = q_q.cnt;

    pwb_slots #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ld || cm_blocked || drain_done),
        .wr_en    (wr),
        .wr_slot  (q_q.cursor),
        .wr_data  (wr_data),
        .rd_slot  (scan_slot),
        .rd_valid (slot_valid),
        .rd_data  (slot_data)
    );

    pwb_drain #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cm_go),
        .page_in    (q_q.base[ADDR_W-1:ADDR_W-ROW_W]),
        .slot_valid (slot_valid),
        .slot_data  (slot_data),
        .busy       (busy),
        .scan_slot  (scan_slot),
        .done       (drain_done),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata)
    );

    pwb_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ld || cm_go),
        .set_val (ld ? load_value : commit_ptr),
        .step_en (rd_adv && !busy),
        .ptr     (rd_addr)
    );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_addr,
    input logic              wr_byte,
    input logic              commit,
    input logic              rd_adv,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [PAGE_W:0]   held_cnt
);
    assert_write_in_scan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_page_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_waddr[ADDR_W-1:PAGE_W]));

    assert_ptr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_addr));

    assert_step_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && !busy && !load_addr && !commit)
        |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

    assert_empty_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !busy && !load_addr && !wr_byte && held_cnt == '0)
        |=> (!busy && $stable(rd_addr)));
endmodule

bind page_write_buffer pwb_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_addr (load_addr),
    .wr_byte   (wr_byte),
    .commit    (commit),
    .rd_adv    (rd_adv),
    .busy      (busy),
    .rd_addr   (rd_addr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .held_cnt  (held_cnt)
);

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_addr = 1'b0;
    logic [10:0] load_value = '0;
    logic        wr_byte = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        commit = 1'b0;
    logic        rd_adv = 1'b0;
    logic        wp = 1'b0;
    logic        busy, mem_we;
    logic [10:0] rd_addr, mem_waddr;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    page_write_buffer uut (
        .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .load_value(load_value),
        .wr_byte(wr_byte), .wr_data(wr_data), .commit(commit), .rd_adv(rd_adv),
        .wp(wp), .busy(busy), .rd_addr(rd_addr), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    // Capture of array writes
    int          cap_n = 0;
    logic [10:0] cap_a [32];
    logic [7:0]  cap_d [32];
    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            if (cap_n < 32) begin
                cap_a[cap_n] = mem_waddr;
                cap_d[cap_n] = mem_wdata;
            end
            cap_n = cap_n + 1;
        end
    end

    // {base, byte count, wp held, expected pointer}
    localparam logic [27:0] VEC [8] = '{
        {11'h123, 5'd1,  1'b0, 11'h124},
        {11'h12F, 5'd1,  1'b0, 11'h120},
        {11'h200, 5'd16, 1'b0, 11'h200},
        {11'h305, 5'd20, 1'b0, 11'h305},
        {11'h40C, 5'd6,  1'b0, 11'h402},
        {11'h500, 5'd3,  1'b1, 11'h500},
        {11'h7F0, 5'd15, 1'b0, 11'h7FF},
        {11'h050, 5'd0,  1'b0, 11'h050}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [10:0] a);
        load_addr = 1'b1; load_value = a;
        @(negedge clk);
        load_addr = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        wr_byte = 1'b1; wr_data = d;
        @(negedge clk);
        wr_byte = 1'b0;
    endtask

    task automatic do_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic do_adv();
        rd_adv = 1'b1;
        @(negedge clk);
        rd_adv = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 64) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int blen;
        repeat (3) @(negedge clk);
        chk(rd_addr == 11'h0 && !busy && !mem_we, "R1 reset", rd_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_addr == 11'h0 && !busy && !mem_we, "R1 after reset", rd_addr, 0);

        // Vector table: R3 R4 R5 R6 R8 R9
        for (int i = 0; i < 8; i++) begin
            logic [10:0] base, expp;
            logic [4:0]  n;
            logic        wpv;
            logic        mv [16];
            logic [7:0]  md [16];
            int          nexp, j;
            {base, n, wpv, expp} = VEC[i];
            for (int s = 0; s < 16; s++) begin mv[s] = 1'b0; md[s] = 8'h00; end
            for (int k = 0; k < int'(n); k++) begin
                int s;
                s = (int'(base[3:0]) + k) % 16;
                mv[s] = 1'b1;
                md[s] = 8'(i * 37 + k * 11 + 5);
            end
            nexp = 0;
            if (!wpv && n != 0)
                for (int s = 0; s < 16; s++) if (mv[s]) nexp++;
            cap_n = 0;
            wp = wpv;
            do_load(base);
            for (int k = 0; k < int'(n); k++) do_byte(8'(i * 37 + k * 11 + 5));
            do_commit();
            wp = 1'b0;
            busy_len(blen);
            @(negedge clk);
            chk(blen == (nexp != 0 ? 16 : 0), "R4/R8/R9 busy length", blen, nexp != 0 ? 16 : 0);
            chk(cap_n == nexp, "R3/R4/R9 write count", cap_n, nexp);
            j = 0;
            for (int s = 0; s < 16 && nexp != 0; s++) begin
                if (mv[s] && j < cap_n && j < 32) begin
                    chk(cap_a[j] == {base[10:4], 4'(s)}, "R4 write address", cap_a[j], {base[10:4], 4'(s)});
                    chk(cap_d[j] == md[s], "R3 last byte kept", cap_d[j], md[s]);
                    j++;
                end
            end
            chk(rd_addr == expp, "R5/R6/R8/R9 pointer after commit", rd_addr, expp);
        end

        // R7: pointer step and wrap at the top address
        do_load(11'h7FF);
        chk(rd_addr == 11'h7FF, "R2 load sets pointer", rd_addr, 11'h7FF);
        do_adv();
        chk(rd_addr == 11'h000, "R7 wrap 2047 to 0", rd_addr, 0);
        do_adv();
        chk(rd_addr == 11'h001, "R7 step", rd_addr, 1);

        // R9: one-cycle protect pulse mid-transfer, then a repeat commit
        cap_n = 0;
        do_load(11'h600);
        do_byte(8'h5A);
        wp = 1'b1;
        @(negedge clk);
        wp = 1'b0;
        do_byte(8'hA5);
        do_commit();
        busy_len(blen);
        chk(blen == 0 && cap_n == 0, "R9 pulse blocks commit", cap_n, 0);
        chk(rd_addr == 11'h600, "R9 pointer unchanged", rd_addr, 11'h600);
        do_commit();
        busy_len(blen);
        chk(cap_n == 0 && blen == 0, "R9 bytes dropped", cap_n, 0);

        // R10: commands during the scan are ignored
        cap_n = 0;
        do_load(11'h010);
        do_byte(8'hAA);
        do_byte(8'hBB);
        do_commit();
        do_load(11'h333);
        do_byte(8'hCC);
        do_adv();
        do_commit();
        busy_len(blen);
        @(negedge clk);
        chk(cap_n == 2, "R10 write count", cap_n, 2);
        chk(rd_addr == 11'h012, "R10 pointer", rd_addr, 11'h012);
        do_commit();
        busy_len(blen);
        chk(cap_n == 2 && blen == 0, "R10 byte during scan ignored", cap_n, 2);

        // R2: a new load discards bytes from the earlier sequence
        cap_n = 0;
        do_load(11'h100);
        do_byte(8'h11);
        do_load(11'h108);
        do_byte(8'h22);
        do_commit();
        busy_len(blen);
        @(negedge clk);
        chk(cap_n == 1, "R2 only new byte written", cap_n, 1);
        chk(cap_a[0] == 11'h108 && cap_d[0] == 8'h22, "R2 write content", cap_a[0], 11'h108);
        chk(rd_addr == 11'h109, "R5 pointer after reload", rd_addr, 11'h109);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule